// File: doc/BRIEF.md
# Stereo-Layer Track Intercept and Dip Fitter

This block takes one candidate track at a time, described by six stereo-layer angle measurements and a shared angle offset, a curvature correction and a small curvature index. It also takes a six-bit mask that marks which layers saw a hit. For each layer it corrects the angle with a curvature-dependent slope term and turns the corrected angle into a z coordinate. It then adds up two weighted sums over the layers whose hit bit is set. A straight-line fit through those points is solved in closed form. Constants come from tables indexed by hit pattern and curvature index, and the multiply-and-shift arithmetic needs no divider. The block returns the z intercept (z0), the dip slope, a tabulated z0 error and the hit mask. All table contents are computed constants held in the package.

Seeds enter on a valid/ready stream and results leave on another. A seed is taken on a rising edge where `in_valid` and `in_ready` are both high. The pipeline has a fixed depth and moves only while the output is free, meaning `out_valid` is low or `out_ready` is high. When the consumer holds `out_ready` low while a result is waiting, every stage freezes, the result stays on the output unchanged, and `in_ready` drops. After each accepted seed, `in_ready` also stays low for a minimum spacing counted in cycles in which the pipeline moves. With `out_ready` held high, each result shows up as a one-cycle `out_valid` pulse at a fixed latency.

Top module: `stereo_z0_fitter`

## Requirements
- R1: A seed is accepted only on a rising edge with `in_valid` and `in_ready` high; `in_ready` is low whenever `out_valid` is high and `out_ready` is low.
- R2: After an accepted seed, `in_ready` stays low for the next MIN_GAP-1 (14) advancing cycles, so accepted seeds are at least MIN_GAP (15) advancing cycles apart.
- R3: With `out_ready` held high, `out_valid` rises after the LATENCY-th (37th) rising edge, counting the accepting edge as the first, and stays high for exactly one cycle.
- R4: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_z0`, `out_dip`, `out_z0err` and `out_hits` hold their values, and no result is lost.
- R5: `out_hits` equals the `in_hits` of the same seed; bit i marks layer i as hit.
- R6: Layer i's angle is bits [i*12 +: 12] of `in_ang` (two's complement). Its corrected angle is ang - offset + ((slope(i,c) * dcurv) >>> 6), with slope(i,c) = (i+1)*(c+1) - 20 and c = `in_cidx`.
- R7: The z value of layer i is (rad(i) * corrected angle) >>> 8, with rad(i) = 40 + 8*i.
- R8: Over the layers whose hit bit is set, S1 = sum of z*(3+i) and S2 = sum of z*(2*i - c + 1). Layers whose bit is clear add nothing, so an empty mask gives z0 = 0 and dip = 0.
- R9: `out_z0` is the low OUT_W (24) bits of (((S1*T1) >>> 6) - ((S2*T2) >>> 6)) * D >>> 16. Here T1 = 16*popcount(h) + c, T2 = (h mod 16) + 2*c and D = 512 + 4*h - 16*c, where h is the mask read as an unsigned number.
- R10: `out_dip` is the low OUT_W bits of (((S2*T3) >>> 1) - ((S1*T2) >>> 1)) * D >>> 16, with T3 = 100 - 7*popcount(h).
- R11: `out_z0err` = (popcount(h) + c) mod 16.
- R12: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Seed offered |
| in_ready | output | 1 | Block can take a seed this cycle |
| in_ang | input | 72 | Six signed 12-bit layer angles, layer i at [i*12 +: 12] |
| in_off | input | 12 | Signed angle offset |
| in_dcurv | input | 10 | Signed curvature correction |
| in_cidx | input | 3 | Refined curvature index |
| in_hits | input | 6 | Hit mask, bit i for layer i |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_z0 | output | 24 | Fitted z intercept, two's complement |
| out_dip | output | 24 | Fitted dip slope, two's complement |
| out_z0err | output | 4 | Tabulated z0 error |
| out_hits | output | 6 | Hit mask of the seed |

## Verification
The assertions rely on the consumer eventually raising `out_ready`, and on `in_valid` being able to sit high while `in_ready` is low without anything being taken. The one-cycle output pulse follows from the spacing counter, which keeps accepted seeds far enough apart in the pipeline. The stimulus offers seeds only through a task that waits for `in_ready`. It stalls the output on purpose in one case, and it draws angles, offsets, curvature terms, indices and masks from their full signed or unsigned ranges, so every value it drives is one the port can legally carry.

// File: rtl/zfit_pkg.sv
package zfit_pkg;
  localparam int NLAY  = 6;
  localparam int ACC_W = 48;

  // per-layer tables
  function automatic int tbl_slope(int i, int c);
    return (i + 1) * (c + 1) - 20;
  endfunction

  function automatic int tbl_rad(int i);
    return 40 + 8 * i;
  endfunction

  function automatic int tbl_sw(int i);
    return 3 + i;
  endfunction

  function automatic int tbl_dsw(int i, int c);
    return 2 * i - c + 1;
  endfunction

  // hit-pattern tables
  function automatic int tbl_pop(int h);
    return $countones(h[NLAY-1:0]);
  endfunction

  function automatic int tbl_t1(int h, int c);
    return 16 * tbl_pop(h) + c;
  endfunction

  function automatic int tbl_t2(int h, int c);
    return (h & 15) + 2 * c;
  endfunction

  function automatic int tbl_t3(int h);
    return 100 - 7 * tbl_pop(h);
  endfunction

  function automatic int tbl_den(int h, int c);
    return 512 + 4 * h - 16 * c;
  endfunction

  function automatic int tbl_err(int h, int c);
    return (tbl_pop(h) + c) & 15;
  endfunction
endpackage

// File: rtl/zfit_delay.sv
module zfit_delay #(
  parameter int W     = 8,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] sr [DEPTH];

  generate
    for (genvar k = 0; k < DEPTH; k++) begin : g_tap
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  sr[k] <= '0;
        else if (en) sr[k] <= (k == 0) ? d : sr[(k == 0) ? 0 : k - 1];
      end
    end
  endgenerate

  assign q = sr[DEPTH-1];
endmodule

// File: rtl/zfit_layer.sv
module zfit_layer
  import zfit_pkg::*;
#(
  parameter int IDX   = 0,
  parameter int ANG_W = 12,
  parameter int DC_W  = 10,
  parameter int CI_W  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic signed [ANG_W-1:0] ang,
  input  logic signed [ANG_W-1:0] off,
  input  logic signed [DC_W-1:0]  dcurv,
  input  logic [CI_W-1:0]         cidx,
  input  logic                    hit,
  output logic signed [ACC_W-1:0] term_w,
  output logic signed [ACC_W-1:0] term_d
);
  logic signed [ACC_W-1:0] corr_n, corr_q, z_n, z_q, slope_e, rad_e, sw_e, dsw_e;
  logic [CI_W-1:0] c1_q, c2_q;
  logic            h1_q, h2_q;

  // stage 1: offset and curvature-slope correction
  always_comb begin
    slope_e = ACC_W'(tbl_slope(IDX, int'(cidx)));
    corr_n  = ACC_W'(ang) - ACC_W'(off) + ((slope_e * ACC_W'(dcurv)) >>> 6);
  end

  // stage 2: angle to z
  always_comb begin
    rad_e = ACC_W'(tbl_rad(IDX));
    z_n   = (rad_e * corr_q) >>> 8;
  end

  // stage 3: weights, masked by hit
  always_comb begin
    sw_e  = ACC_W'(tbl_sw(IDX));
    dsw_e = ACC_W'(tbl_dsw(IDX, int'(c2_q)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      corr_q <= '0; c1_q <= '0; h1_q <= 1'b0;
      z_q    <= '0; c2_q <= '0; h2_q <= 1'b0;
      term_w <= '0; term_d <= '0;
    end else if (en) begin
      corr_q <= corr_n;
      c1_q   <= cidx;
      h1_q   <= hit;
      z_q    <= z_n;
      c2_q   <= c1_q;
      h2_q   <= h1_q;
      term_w <= h2_q ? z_q * sw_e  : '0;
      term_d <= h2_q ? z_q * dsw_e : '0;
    end
  end
endmodule

// File: rtl/zfit_solve.sv
module zfit_solve
  import zfit_pkg::*;
#(
  parameter int CI_W  = 3,
  parameter int OUT_W = 24,
  parameter int ERR_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    v_in,
  input  logic [NLAY-1:0]         hits,
  input  logic [CI_W-1:0]         cidx,
  input  logic signed [ACC_W-1:0] tw [NLAY],
  input  logic signed [ACC_W-1:0] td [NLAY],
  output logic                    v_out,
  output logic [NLAY-1:0]         hits_out,
  output logic [ERR_W-1:0]        err_out,
  output logic [OUT_W-1:0]        z0_out,
  output logic [OUT_W-1:0]        dip_out
);
  logic signed [ACC_W-1:0] s1_n, s2_n, s1_q, s2_q;
  logic signed [ACC_W-1:0] t1_q, t2_q, t3_q, den4_q, den5_q;
  logic signed [ACC_W-1:0] p1_q, p2_q, p3_q, p4_q, fz, fd;
  logic [ERR_W-1:0]        err4_q, err5_q;
  logic [NLAY-1:0]         h4_q, h5_q;
  logic                    v4_q, v5_q;

  // stage 4: sums and table reads
  always_comb begin
    s1_n = '0;
    s2_n = '0;
    for (int i = 0; i < NLAY; i++) begin
      s1_n = s1_n + tw[i];
      s2_n = s2_n + td[i];
    end
  end

  // stage 6: closed-form line solution
  always_comb begin
    fz = ((p1_q - p2_q) * den5_q) >>> 16;
    fd = ((p3_q - p4_q) * den5_q) >>> 16;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0; s2_q <= '0; t1_q <= '0; t2_q <= '0; t3_q <= '0;
      den4_q <= '0; err4_q <= '0; h4_q <= '0; v4_q <= 1'b0;
      p1_q <= '0; p2_q <= '0; p3_q <= '0; p4_q <= '0;
      den5_q <= '0; err5_q <= '0; h5_q <= '0; v5_q <= 1'b0;
      z0_out <= '0; dip_out <= '0; err_out <= '0; hits_out <= '0; v_out <= 1'b0;
    end else if (en) begin
      s1_q   <= s1_n;
      s2_q   <= s2_n;
      t1_q   <= ACC_W'(tbl_t1(int'(hits), int'(cidx)));
      t2_q   <= ACC_W'(tbl_t2(int'(hits), int'(cidx)));
      t3_q   <= ACC_W'(tbl_t3(int'(hits)));
      den4_q <= ACC_W'(tbl_den(int'(hits), int'(cidx)));
      err4_q <= ERR_W'(tbl_err(int'(hits), int'(cidx)));
      h4_q   <= hits;
      v4_q   <= v_in;
      // stage 5: weighted products
      p1_q   <= (s1_q * t1_q) >>> 6;
      p2_q   <= (s2_q * t2_q) >>> 6;
      p3_q   <= (s2_q * t3_q) >>> 1;
      p4_q   <= (s1_q * t2_q) >>> 1;
      den5_q <= den4_q;
      err5_q <= err4_q;
      h5_q   <= h4_q;
      v5_q   <= v4_q;
      // stage 6 registers
      z0_out   <= fz[OUT_W-1:0];
      dip_out  <= fd[OUT_W-1:0];
      err_out  <= err5_q;
      hits_out <= h5_q;
      v_out    <= v5_q;
    end
  end
endmodule

// File: rtl/stereo_z0_fitter.sv
module stereo_z0_fitter
  import zfit_pkg::*;
#(
  parameter int ANG_W   = 12,
  parameter int DC_W    = 10,
  parameter int CI_W    = 3,
  parameter int OUT_W   = 24,
  parameter int ERR_W   = 4,
  parameter int LATENCY = 37,
  parameter int MIN_GAP = 15
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [NLAY*ANG_W-1:0]  in_ang,
  input  logic [ANG_W-1:0]       in_off,
  input  logic [DC_W-1:0]        in_dcurv,
  input  logic [CI_W-1:0]        in_cidx,
  input  logic [NLAY-1:0]        in_hits,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [OUT_W-1:0]       out_z0,
  output logic [OUT_W-1:0]       out_dip,
  output logic [ERR_W-1:0]       out_z0err,
  output logic [NLAY-1:0]        out_hits
);
  localparam int CORE_ST = 7;                 // S0 hold + 3 layer + 3 solve
  localparam int PAD     = LATENCY - CORE_ST;
  localparam int GAP_W   = $clog2(MIN_GAP + 1);
  localparam int SIDE_W  = 1 + CI_W + NLAY;
  localparam int RES_W   = 1 + NLAY + ERR_W + 2 * OUT_W;

  logic en, acc;
  logic [GAP_W-1:0] gap_q;

  // S0 hold register
  logic                    s0_v;
  logic [NLAY*ANG_W-1:0]   s0_ang;
  logic signed [ANG_W-1:0] s0_off;
  logic signed [DC_W-1:0]  s0_dc;
  logic [CI_W-1:0]         s0_c;
  logic [NLAY-1:0]         s0_h;

  logic [SIDE_W-1:0]       side_q;
  logic signed [ACC_W-1:0] tw [NLAY];
  logic signed [ACC_W-1:0] td [NLAY];

  logic                    sv_v;
  logic [NLAY-1:0]         sv_h;
  logic [ERR_W-1:0]        sv_err;
  logic [OUT_W-1:0]        sv_z0, sv_dip;
  logic [RES_W-1:0]        res_q;

  assign en       = !out_valid || out_ready;
  assign in_ready = en && (gap_q == '0);
  assign acc      = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= '0;
    end else if (acc) begin
      gap_q <= GAP_W'(MIN_GAP - 1);
    end else if (en && gap_q != '0) begin
      gap_q <= gap_q - GAP_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0_v <= 1'b0; s0_ang <= '0; s0_off <= '0; s0_dc <= '0; s0_c <= '0; s0_h <= '0;
    end else if (en) begin
      s0_v <= acc;
      if (acc) begin
        s0_ang <= in_ang;
        s0_off <= in_off;
        s0_dc  <= in_dcurv;
        s0_c   <= in_cidx;
        s0_h   <= in_hits;
      end
    end
  end

  generate
    for (genvar g = 0; g < NLAY; g++) begin : g_lay
      zfit_layer #(.IDX(g), .ANG_W(ANG_W), .DC_W(DC_W), .CI_W(CI_W)) lay_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en),
        .ang    (s0_ang[g*ANG_W +: ANG_W]),
        .off    (s0_off),
        .dcurv  (s0_dc),
        .cidx   (s0_c),
        .hit    (s0_h[g]),
        .term_w (tw[g]),
        .term_d (td[g])
      );
    end
  endgenerate

  // valid, index and mask ride alongside the three layer stages
  zfit_delay #(.W(SIDE_W), .DEPTH(3)) side_i (
    .clk (clk), .rst_n (rst_n), .en (en),
    .d   ({s0_v, s0_c, s0_h}),
    .q   (side_q)
  );

  zfit_solve #(.CI_W(CI_W), .OUT_W(OUT_W), .ERR_W(ERR_W)) solve_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .v_in     (side_q[SIDE_W-1]),
    .hits     (side_q[NLAY-1:0]),
    .cidx     (side_q[NLAY +: CI_W]),
    .tw       (tw),
    .td       (td),
    .v_out    (sv_v),
    .hits_out (sv_h),
    .err_out  (sv_err),
    .z0_out   (sv_z0),
    .dip_out  (sv_dip)
  );

  zfit_delay #(.W(RES_W), .DEPTH(PAD)) pad_i (
    .clk (clk), .rst_n (rst_n), .en (en),
    .d   ({sv_v, sv_h, sv_err, sv_dip, sv_z0}),
    .q   (res_q)
  );

  assign {out_valid, out_hits, out_z0err, out_dip, out_z0} = res_q;
endmodule

// File: rtl/stereo_z0_fitter_chk.sv
module stereo_z0_fitter_chk
  import zfit_pkg::*;
#(
  parameter int OUT_W = 24,
  parameter int ERR_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [OUT_W-1:0] out_z0,
  input logic [OUT_W-1:0] out_dip,
  input logic [ERR_W-1:0] out_z0err,
  input logic [NLAY-1:0]  out_hits
);
  assert_no_take_in_stall_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> !out_valid);

  assert_stall_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_z0) && $stable(out_dip)
                                   && $stable(out_z0err) && $stable(out_hits)));
endmodule

bind stereo_z0_fitter stereo_z0_fitter_chk #(.OUT_W(OUT_W), .ERR_W(ERR_W)) chk_i (.*);

// File: tb/stereo_z0_fitter_tb_top.sv
module stereo_z0_fitter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ANG_W = 12, DC_W = 10, CI_W = 3, OUT_W = 24, ERR_W = 4, NL = 6;
  localparam int LAT = 37, GAP = 15;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic in_ready, out_valid;
  logic [NL*ANG_W-1:0] in_ang = '0;
  logic [ANG_W-1:0] in_off = '0;
  logic [DC_W-1:0] in_dcurv = '0;
  logic [CI_W-1:0] in_cidx = '0;
  logic [NL-1:0] in_hits = '0;
  logic [OUT_W-1:0] out_z0, out_dip;
  logic [ERR_W-1:0] out_z0err;
  logic [NL-1:0] out_hits;

  stereo_z0_fitter dut_i (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic chk(bit ok, string req, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference model from the requirement formulas
  function automatic int pc(int h);
    int n = 0;
    for (int k = 0; k < NL; k++) n += (h >> k) & 1;
    return n;
  endfunction

  task automatic model(input int ang[NL], input int off, input int dc, input int c, input int h,
                       output longint z0, output longint dip, output int err);
    longint s1 = 0, s2 = 0, corr, z, t1, t2, t3, den;
    for (int i = 0; i < NL; i++) begin
      corr = longint'(ang[i]) - off + ((longint'((i+1)*(c+1) - 20) * dc) >>> 6);   // R6
      z = (longint'(40 + 8*i) * corr) >>> 8;                                      // R7
      if (((h >> i) & 1) == 1) begin                                              // R8
        s1 += z * (3 + i);
        s2 += z * (2*i - c + 1);
      end
    end
    t1 = 16*pc(h) + c; t2 = (h & 15) + 2*c; t3 = 100 - 7*pc(h); den = 512 + 4*h - 16*c;
    z0  = ((((s1*t1) >>> 6) - ((s2*t2) >>> 6)) * den) >>> 16;
    dip = ((((s2*t3) >>> 1) - ((s1*t2) >>> 1)) * den) >>> 16;
    err = (pc(h) + c) & 15;
  endtask

  task automatic drive(input int ang[NL], input int off, input int dc, input int c, input int h,
                       output longint c0);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    for (int i = 0; i < NL; i++) in_ang[i*ANG_W +: ANG_W] = ang[i][ANG_W-1:0];
    in_off = off[ANG_W-1:0]; in_dcurv = dc[DC_W-1:0];
    in_cidx = c[CI_W-1:0]; in_hits = h[NL-1:0];
    in_valid = 1'b1;
    c0 = cyc;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic check_out(input longint c0, input longint ez0, input longint edip,
                           input int eerr, input int h);
    chk(cyc - c0 == LAT, "R3 latency", cyc - c0, LAT);
    chk(out_z0 == ez0[OUT_W-1:0], "R9 z0 (R6 R7 R8)", longint'($signed(out_z0)), ez0);
    chk(out_dip == edip[OUT_W-1:0], "R10 dip", longint'($signed(out_dip)), edip);
    chk(out_z0err == eerr[ERR_W-1:0], "R11 z0err", out_z0err, eerr);
    chk(out_hits == h[NL-1:0], "R5 hits", out_hits, h);
  endtask

  task automatic run_one(input int ang[NL], input int off, input int dc, input int c,
                         input int h, input bit gapchk);
    longint c0, ez0, edip; int eerr, n;
    model(ang, off, dc, c, h, ez0, edip, eerr);
    drive(ang, off, dc, c, h, c0);
    if (gapchk) begin
      n = 0;
      while (!in_ready) begin n++; @(negedge clk); end
      chk(n == GAP - 1, "R2 gap", n, GAP - 1);
    end
    while (!out_valid) @(negedge clk);
    check_out(c0, ez0, edip, eerr, h);
    @(negedge clk);
    chk(out_valid == 1'b0, "R3 single pulse", out_valid, 0);
  endtask

  function automatic int rs(int w);
    return int'($urandom_range(0, (1 << w) - 1)) - (1 << (w - 1));
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int a[NL];
    longint c0a, c0b, za, da, zb, db, hz, hd; int ea, eb, oldnum, hh, he;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R12 reset out_valid", out_valid, 0);
    chk(in_ready == 1'b1, "R12 reset in_ready", in_ready, 1);

    // all zero input
    for (int i = 0; i < NL; i++) a[i] = 0;
    run_one(a, 0, 0, 0, 6'h3F, 1'b1);
    // empty mask: R8 no contribution
    for (int i = 0; i < NL; i++) a[i] = 300 * (i + 1) - 900;
    run_one(a, 17, 200, 5, 6'h00, 1'b0);
    // extreme positive corner
    for (int i = 0; i < NL; i++) a[i] = 2047;
    run_one(a, -2048, 511, 7, 6'h3F, 1'b0);
    // extreme negative corner, sparse mask
    for (int i = 0; i < NL; i++) a[i] = -2048;
    run_one(a, 2047, -512, 0, 6'h15, 1'b1);

    // overlapping seeds at minimum spacing
    for (int i = 0; i < NL; i++) a[i] = rs(ANG_W);
    model(a, 100, -37, 3, 6'h2B, za, da, ea);
    drive(a, 100, -37, 3, 6'h2B, c0a);
    for (int i = 0; i < NL; i++) a[i] = rs(ANG_W);
    model(a, -55, 250, 6, 6'h36, zb, db, eb);
    drive(a, -55, 250, 6, 6'h36, c0b);
    chk(c0b - c0a == GAP, "R2 accept spacing", c0b - c0a, GAP);
    while (!out_valid) @(negedge clk);
    check_out(c0a, za, da, ea, 6'h2B);
    @(negedge clk);
    while (!out_valid) @(negedge clk);
    check_out(c0b, zb, db, eb, 6'h36);
    @(negedge clk);

    // output stall
    out_ready = 1'b0;
    for (int i = 0; i < NL; i++) a[i] = rs(ANG_W);
    model(a, -300, 77, 2, 6'h1E, za, da, ea);
    drive(a, -300, 77, 2, 6'h1E, c0a);
    while (!out_valid) @(negedge clk);
    check_out(c0a, za, da, ea, 6'h1E);
    chk(in_ready == 1'b0, "R1 no accept while stalled", in_ready, 0);
    hz = longint'(out_z0); hd = longint'(out_dip); hh = int'(out_hits); he = int'(out_z0err);
    oldnum = 0;
    repeat (6) begin
      @(negedge clk);
      if (out_valid && longint'(out_z0) == hz && longint'(out_dip) == hd
          && int'(out_hits) == hh && int'(out_z0err) == he) oldnum++;
    end
    chk(oldnum == 6, "R4 stall hold", oldnum, 6);
    out_ready = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R4 released after take", out_valid, 0);

    // random seeds
    for (int n = 0; n < 40; n++) begin
      for (int i = 0; i < NL; i++) a[i] = rs(ANG_W);
      run_one(a, rs(ANG_W), rs(DC_W), int'($urandom_range(0, 7)),
              int'($urandom_range(0, 63)), (n % 8) == 0);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule